// File: doc/BRIEF.md
# Not-Recently-Used Eviction Frame Picker

This block tracks two flags for each resident physical frame. The usage flag records that the frame was touched since the last sweep. The modified flag records that the frame was written since it was loaded. When a replacement is requested, the block names the frame to evict. Frames fall into four ranks built from the two flags. The block picks from the lowest rank that has any member. Ties inside a rank are broken by a rotating start position, so repeated evictions spread across the frames. The block also reports whether the chosen frame holds modified data that must be written back first.

A memory manager drives one access event per cycle, each with a frame index and a write flag. It pulses a sweep input periodically to age the usage flags. It asserts a load strobe when a fresh page has been placed in a frame. The picker only decides. Moving page contents is done elsewhere.

Top module: `nru_victim_sel`

## Requirements
- R1: An access event to frame f sets the usage flag of f on the next clock edge, for both reads and writes.
- R2: A write access (acc_write=1) to frame f sets the modified flag of f. A read access (acc_write=0) leaves the modified flag unchanged.
- R3: A sweep pulse clears the usage flag of every frame and leaves every modified flag unchanged. If an access event arrives in the same cycle as a sweep, the accessed frame ends with its usage flag set.
- R4: The rank of a frame is {modified, usage}. Rank 0 is clean and unused, rank 1 is clean and used, rank 2 is modified and unused, and rank 3 is modified and used. The victim always comes from the lowest rank that has at least one frame.
- R5: Within that rank, the victim is the first member found when scanning upward from a start pointer and wrapping past the top index. The pointer is 0 after reset. After each pick it becomes the victim index plus one, modulo the frame count.
- R6: A victim request (vic_req=1) in one cycle produces vic_valid=1 in the next cycle, with vic_idx chosen from the flags as they stood before that edge. Without a request, vic_valid is 0.
- R7: vic_dirty equals the modified flag of the chosen frame at selection time. 1 means write-back is required.
- R8: A load strobe for frame f clears both flags of f. If an access to the same frame arrives in the same cycle, the load takes precedence.
- R9: After reset, all flags are clear, the pointer is 0 and vic_valid is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| acc_valid | input | 1 | Access event strobe |
| acc_idx | input | IDX_W | Frame touched by the access |
| acc_write | input | 1 | Access is a write |
| clear_pulse | input | 1 | Periodic sweep of usage flags |
| load_valid | input | 1 | Fresh page placed in a frame |
| load_idx | input | IDX_W | Frame that was reloaded |
| vic_req | input | 1 | Request an eviction choice |
| vic_valid | output | 1 | Victim result strobe |
| vic_idx | output | IDX_W | Chosen frame |
| vic_dirty | output | 1 | Chosen frame needs write-back |

## Verification
The flags are visible only through the choices the picker makes. A stuck or lost usage or modified flag therefore shows up as a wrong vic_idx or vic_dirty on the first request after the faulty update. The bench arranges the ranks so that exactly one frame is eligible, or so that the rotation order singles out one frame. A wrong pointer update shows up on the very next back-to-back request. A reversed collision priority between sweep and access, or between load and access, moves the choice to a different frame that the bench predicts.

// File: rtl/nru_pkg.sv
package nru_pkg;
   localparam int NUM_RANKS = 4;

   typedef enum logic [1:0] {
      RANK_CLEAN_IDLE = 2'd0,
      RANK_CLEAN_USED = 2'd1,
      RANK_DIRTY_IDLE = 2'd2,
      RANK_DIRTY_USED = 2'd3
   } nru_rank_e;
endpackage

// File: rtl/nru_flag_bank.sv
module nru_flag_bank #(
   parameter int NFRAMES = 8,
   parameter int IDX_W   = $clog2(NFRAMES)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               acc_valid,
   input  logic [IDX_W-1:0]   acc_idx,
   input  logic               acc_write,
   input  logic               clear_pulse,
   input  logic               load_valid,
   input  logic [IDX_W-1:0]   load_idx,
   output logic [NFRAMES-1:0] used_q,
   output logic [NFRAMES-1:0] mod_q
);
   for (genvar f = 0; f < NFRAMES; f++) begin : g_frame
      logic hit, reload;
      assign hit    = acc_valid  && (acc_idx  == IDX_W'(f));
      assign reload = load_valid && (load_idx == IDX_W'(f));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            used_q[f] <= 1'b0;
            mod_q[f]  <= 1'b0;
         end else if (reload) begin
            used_q[f] <= 1'b0;
            mod_q[f]  <= 1'b0;
         end else begin
            if (hit)              used_q[f] <= 1'b1;
            else if (clear_pulse) used_q[f] <= 1'b0;
            if (hit && acc_write) mod_q[f]  <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/nru_rank_sel.sv
module nru_rank_sel
   import nru_pkg::*;
#(
   parameter int NFRAMES = 8
) (
   input  logic [NFRAMES-1:0] used_q,
   input  logic [NFRAMES-1:0] mod_q,
   output logic [NFRAMES-1:0] cand_mask
);
   logic [NUM_RANKS-1:0][NFRAMES-1:0] rank_mask;

   for (genvar r = 0; r < NUM_RANKS; r++) begin : g_rank
      for (genvar f = 0; f < NFRAMES; f++) begin : g_fr
         assign rank_mask[r][f] = ({mod_q[f], used_q[f]} == 2'(r));
      end
   end

   always_comb begin
      cand_mask = '0;
      for (int r = NUM_RANKS - 1; r >= 0; r--) begin
         if (|rank_mask[r]) cand_mask = rank_mask[r];
      end
   end
endmodule

// File: rtl/nru_rot_pick.sv
module nru_rot_pick #(
   parameter int NFRAMES = 8,
   parameter int IDX_W   = $clog2(NFRAMES)
) (
   input  logic [NFRAMES-1:0] cand_mask,
   input  logic [IDX_W-1:0]   start,
   output logic [IDX_W-1:0]   pick_idx
);
   localparam bit POW2 = (NFRAMES == (1 << IDX_W));

   function automatic logic [IDX_W-1:0] wrap_add(logic [IDX_W-1:0] a, int k);
      logic [IDX_W:0] s;
      s = {1'b0, a} + (IDX_W+1)'(k);
      if (POW2) return s[IDX_W-1:0];
      else if (s >= (IDX_W+1)'(NFRAMES)) return IDX_W'(s - (IDX_W+1)'(NFRAMES));
      else return s[IDX_W-1:0];
   endfunction

   always_comb begin
      logic found;
      logic [IDX_W-1:0] probe;
      found    = 1'b0;
      pick_idx = start;
      for (int k = 0; k < NFRAMES; k++) begin
         probe = wrap_add(start, k);
         if (!found && cand_mask[probe]) begin
            found    = 1'b1;
            pick_idx = probe;
         end
      end
   end
endmodule

// File: rtl/nru_victim_sel.sv
module nru_victim_sel #(
   parameter int NFRAMES = 8,
   parameter int IDX_W   = $clog2(NFRAMES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             acc_valid,
   input  logic [IDX_W-1:0] acc_idx,
   input  logic             acc_write,
   input  logic             clear_pulse,
   input  logic             load_valid,
   input  logic [IDX_W-1:0] load_idx,
   input  logic             vic_req,
   output logic             vic_valid,
   output logic [IDX_W-1:0] vic_idx,
   output logic             vic_dirty
);
   localparam bit POW2 = (NFRAMES == (1 << IDX_W));

   if (NFRAMES < 2) begin : g_bad_count
      $error("nru_victim_sel: NFRAMES must be at least 2");
   end
   if (IDX_W < $clog2(NFRAMES)) begin : g_bad_width
      $error("nru_victim_sel: IDX_W too narrow for NFRAMES");
   end

   logic [NFRAMES-1:0] acc_bits, dirty_bits, cand_mask;
   logic [IDX_W-1:0]   ptr_q, pick_idx, ptr_next;

   nru_flag_bank #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_flags (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
      .clear_pulse(clear_pulse),
      .load_valid(load_valid), .load_idx(load_idx),
      .used_q(acc_bits), .mod_q(dirty_bits)
   );

   nru_rank_sel #(.NFRAMES(NFRAMES)) u_rank (
      .used_q(acc_bits), .mod_q(dirty_bits), .cand_mask(cand_mask)
   );

   nru_rot_pick #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_pick (
      .cand_mask(cand_mask), .start(ptr_q), .pick_idx(pick_idx)
   );

   if (POW2) begin : g_wrap_free
      assign ptr_next = pick_idx + 1'b1;
   end else begin : g_wrap_cmp
      assign ptr_next = (pick_idx == IDX_W'(NFRAMES - 1)) ? '0 : pick_idx + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         ptr_q     <= '0;
         vic_valid <= 1'b0;
         vic_idx   <= '0;
         vic_dirty <= 1'b0;
      end else begin
         vic_valid <= vic_req;
         if (vic_req) begin
            ptr_q     <= ptr_next;
            vic_idx   <= pick_idx;
            vic_dirty <= dirty_bits[pick_idx];
         end
      end
   end
endmodule

// File: rtl/nru_victim_sel_chk.sv
module nru_victim_sel_chk #(
   parameter int NFRAMES = 8,
   parameter int IDX_W   = $clog2(NFRAMES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               acc_valid,
   input logic [IDX_W-1:0]   acc_idx,
   input logic               acc_write,
   input logic               clear_pulse,
   input logic               load_valid,
   input logic [IDX_W-1:0]   load_idx,
   input logic               vic_req,
   input logic               vic_valid,
   input logic [IDX_W-1:0]   vic_idx,
   input logic               vic_dirty,
   input logic [NFRAMES-1:0] acc_bits,
   input logic [NFRAMES-1:0] dirty_bits
);
   logic [NFRAMES-1:0] dirty_prev;
   always_ff @(posedge clk) begin
      if (!rst_n) dirty_prev <= '0;
      else        dirty_prev <= dirty_bits;
   end

   p_access_sets_used_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && !(load_valid && load_idx == acc_idx)) |=> acc_bits[$past(acc_idx)]);

   p_write_sets_mod_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_valid && acc_write && !(load_valid && load_idx == acc_idx)) |=> dirty_bits[$past(acc_idx)]);

   p_sweep_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (clear_pulse && !acc_valid && !load_valid) |=> (acc_bits == '0 && dirty_bits == $past(dirty_bits)));

   p_grant_timing_r6: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid == $past(vic_req));

   p_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> ({1'b0, vic_idx} < (IDX_W+1)'(NFRAMES)));

   p_writeback_r7: assert property (@(posedge clk) disable iff (!rst_n)
      vic_valid |-> (vic_dirty == dirty_prev[vic_idx]));

   p_load_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
      load_valid |=> (!acc_bits[$past(load_idx)] && !dirty_bits[$past(load_idx)]));
endmodule

bind nru_victim_sel nru_victim_sel_chk #(.NFRAMES(NFRAMES), .IDX_W(IDX_W)) u_chk (.*);

// File: tb/nru_victim_sel_test.sv
module nru_victim_sel_test;
   localparam int N = 8;
   localparam int W = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic acc_valid = 1'b0, acc_write = 1'b0, clear_pulse = 1'b0, load_valid = 1'b0, vic_req = 1'b0;
   logic [W-1:0] acc_idx = '0, load_idx = '0;
   logic vic_valid, vic_dirty;
   logic [W-1:0] vic_idx;

   int checks = 0;
   int errors = 0;

   always #2 clk = ~clk;

   nru_victim_sel #(.NFRAMES(N)) uut (
      .clk(clk), .rst_n(rst_n),
      .acc_valid(acc_valid), .acc_idx(acc_idx), .acc_write(acc_write),
      .clear_pulse(clear_pulse),
      .load_valid(load_valid), .load_idx(load_idx),
      .vic_req(vic_req), .vic_valid(vic_valid), .vic_idx(vic_idx), .vic_dirty(vic_dirty)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic do_reset();
      @(negedge clk);
      rst_n = 1'b0;
      acc_valid = 0; clear_pulse = 0; load_valid = 0; vic_req = 0; acc_write = 0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      check(vic_valid == 1'b0, "R9 vic_valid after reset", int'(vic_valid), 0);
   endtask

   task automatic touch(input int idx, input bit wr, input bit sweep);
      @(negedge clk);
      acc_valid = 1'b1; acc_idx = W'(idx); acc_write = wr; clear_pulse = sweep;
      @(negedge clk);
      acc_valid = 1'b0; acc_write = 1'b0; clear_pulse = 1'b0;
   endtask

   task automatic sweep();
      @(negedge clk);
      clear_pulse = 1'b1;
      @(negedge clk);
      clear_pulse = 1'b0;
   endtask

   task automatic ask(input int exp_idx, input bit exp_dirty, input string req);
      @(negedge clk);
      vic_req = 1'b1;
      @(negedge clk);
      vic_req = 1'b0;
      check(vic_valid == 1'b1, {req, " valid"}, int'(vic_valid), 1);
      check(vic_idx == W'(exp_idx), {req, " idx"}, int'(vic_idx), exp_idx);
      check(vic_dirty == exp_dirty, {req, " dirty"}, int'(vic_dirty), int'(exp_dirty));
   endtask

   task automatic t_reset_rotate();
      do_reset();
      // R9 R5 R6: all rank 0, back-to-back requests walk the pointer and wrap
      @(negedge clk);
      vic_req = 1'b1;
      for (int k = 0; k < N + 1; k++) begin
         @(negedge clk);
         check(vic_valid == 1'b1, "R6 valid per request", int'(vic_valid), 1);
         check(vic_idx == W'(k % N), "R5 rotation order", int'(vic_idx), k % N);
      end
      vic_req = 1'b0;
      @(negedge clk);
      check(vic_valid == 1'b0, "R6 no request no valid", int'(vic_valid), 0);
   endtask

   task automatic t_used_rank();
      do_reset();
      for (int f = 0; f < N; f++) if (f != 5) touch(f, 1'b0, 1'b0);
      ask(5, 1'b0, "R1 R4 only unused frame");
   endtask

   task automatic t_dirty();
      do_reset();
      for (int f = 0; f < N; f++) touch(f, f != 3, 1'b0);
      ask(3, 1'b0, "R2 R4 clean-used beats dirty-used");
      touch(3, 1'b1, 1'b0);
      ask(4, 1'b1, "R2 R7 all dirty, pointer at 4");
   endtask

   task automatic t_sweep();
      do_reset();
      for (int f = 0; f < N; f++) touch(f, f != 6, 1'b0);
      sweep();
      touch(6, 1'b0, 1'b0);
      ask(6, 1'b0, "R4 clean-used beats dirty-idle");
      touch(6, 1'b1, 1'b0);
      ask(7, 1'b1, "R3 dirty kept over sweep");
   endtask

   task automatic t_collide_sweep();
      do_reset();
      for (int f = 0; f < N; f++) touch(f, 1'b0, 1'b0);
      touch(0, 1'b0, 1'b1);
      ask(1, 1'b0, "R3 access beats same-cycle sweep");
   endtask

   task automatic t_load();
      do_reset();
      for (int f = 0; f < N; f++) touch(f, 1'b1, 1'b0);
      @(negedge clk);
      load_valid = 1'b1; load_idx = 3'd5;
      @(negedge clk);
      load_valid = 1'b0;
      ask(5, 1'b0, "R8 load clears flags");
      @(negedge clk);
      load_valid = 1'b1; load_idx = 3'd2;
      acc_valid = 1'b1; acc_idx = 3'd2; acc_write = 1'b1;
      @(negedge clk);
      load_valid = 1'b0; acc_valid = 1'b0; acc_write = 1'b0;
      ask(2, 1'b0, "R8 load beats same-cycle write");
   endtask

   initial begin
      fork
         begin
            t_reset_rotate();
            t_used_rank();
            t_dirty();
            t_sweep();
            t_collide_sweep();
            t_load();
         end
         begin
            repeat (20000) @(posedge clk);
            check(1'b0, "watchdog expired", 0, 1);
         end
      join_any
      disable fork;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule